// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point result into a 32-bit IEEE-754 single-precision word. An unpacked result has a class, a sign, an unbiased exponent, and a mantissa. The mantissa carries an explicit leading one, twenty-three fraction bits and two guard/round bits, with a separate sticky bit beside it. The block sits at the end of an arithmetic datapath.

The block biases the exponent. When the number falls below the normal range, it shifts the number right into the subnormal range. It then rounds in one of four directions and handles the carry that rounding may cause. Results too large for the format saturate to infinity or to the largest finite value, depending on the rounding direction. The block also raises inexact, underflow and overflow flags for the result.

Each accepted input produces its packed word exactly two clock cycles later, marked by `out_valid`. The pipeline accepts a new input every cycle.

Top module: `sp_packer`

## Requirements
- R1: A zero-class input (class code 0) packs as the signed zero (sign in bit 31, all other bits 0) and raises no flag.
- R2: An infinity-class input (class code 2) packs as sign, exponent field 255, fraction 0, with no flag.
- R3: A NaN-class input (class code 3) packs with exponent field 255. Its fraction field is the 23 mantissa bits below the leading one (`in_mant[24:2]`), with fraction bit 22 forced to 1. No flag is raised.
- R4: A number-class input (class code 1) with biased exponent `in_exp + 127` of at least 1 packs as that exponent in bits 30:23 and `in_mant[24:2]` in bits 22:0. When `in_mant[1:0]` and `in_sticky` are all zero, no flag is raised.
- R5: The rounding mode codes are 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. Nearest-even adds one when the guard bit (`in_mant[1]`) is set and either the round bit, the sticky bit or the kept LSB is set. Toward zero never adds one. Toward +infinity adds one for any nonzero discarded bits of a positive value, and toward -infinity does the same for a negative value. Inexact is set whenever any discarded bit is nonzero.
- R6: When rounding a normal carries the mantissa to 2.0, the exponent field goes up by one and the fraction field is zero.
- R7: When the final biased exponent is 255 or more, overflow and inexact are both set. The result is infinity in the nearest mode, in the +infinity mode for a positive value, and in the -infinity mode for a negative value. In every other case it is exponent 254 with an all-ones fraction.
- R8: A number whose biased exponent `b` is 0 or less is shifted right by `1 - b` bit places, and the bits shifted out join the sticky bit. The result is then rounded and packed with exponent field 0.
- R9: A subnormal that rounds up into the leading-one position packs as the smallest normal (exponent 1, fraction 0). It sets inexact and does not set underflow.
- R10: A result that stays subnormal raises underflow exactly when it is inexact or when `uf_trap_en` is set.
- R11: `out_valid` is high exactly two rising clock edges after an edge that samples `in_valid` high, with one result for each input and back-to-back inputs accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W (10) | Unbiased exponent, two's complement |
| in_mant | input | 26 | Leading one, 23 fraction bits, guard, round |
| in_sticky | input | 1 | OR of all bits below the round bit |
| rnd_mode | input | 2 | Rounding direction code (R5) |
| uf_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Packed word valid |
| out_word | output | 32 | Single-precision result |
| out_inexact | output | 1 | Result was rounded |
| out_underflow | output | 1 | Subnormal result, inexact or trapped |
| out_overflow | output | 1 | Exponent exceeded the format |

## Verification
The hardest case to reach is a value at the very edge of the subnormal range. There the alignment shift moves bits into the guard and sticky positions, and rounding then carries into the leading-one position, so the word becomes the smallest normal and underflow must stay clear. The stimulus reaches it by sending biased exponent 0 with an all-ones fraction and both guard bits set. A neighbouring exact subnormal is sent with the trap enable on and off, which separates the two causes of underflow. A very small exponent forces the shift clamp, so the whole mantissa goes into the sticky bit, and the directed-rounding modes must then produce zero or the least subnormal.

// File: rtl/spk_pkg.sv
package spk_pkg;
    localparam int FRAC_W  = 23;
    localparam int EFLD_W  = 8;
    localparam int BIAS    = 127;
    localparam int GR_W    = 2;
    localparam int KEEP_W  = FRAC_W + 1;
    localparam int MANT_W  = KEEP_W + GR_W;
    localparam int EMAX    = (1 << EFLD_W) - 1;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;
endpackage

// File: rtl/spk_align.sv
module spk_align #(
    parameter int MW   = 26,
    parameter int SH_W = $clog2(MW + 1)
) (
    input  logic [MW-1:0]   mant_i,
    input  logic            sticky_i,
    input  logic [SH_W-1:0] shamt_i,
    output logic [MW-1:0]   mant_o,
    output logic            sticky_o
);
    logic [2*MW-1:0] ext;

    always_comb begin
        ext      = {mant_i, {MW{1'b0}}} >> shamt_i;
        mant_o   = ext[2*MW-1:MW];
        sticky_o = sticky_i | (|ext[MW-1:0]);
    end
endmodule

// File: rtl/spk_round.sv
module spk_round
    import spk_pkg::*;
(
    input  rmode_e     mode_i,
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic [1:0] gr_i,
    input  logic       sticky_i,
    output logic       inc_o,
    output logic       inexact_o,
    output logic       to_inf_o
);
    always_comb begin
        inexact_o = (|gr_i) | sticky_i;
        unique case (mode_i)
            RM_NEAR: begin
                inc_o    = gr_i[1] & (gr_i[0] | sticky_i | lsb_i);
                to_inf_o = 1'b1;
            end
            RM_ZERO: begin
                inc_o    = 1'b0;
                to_inf_o = 1'b0;
            end
            RM_UP: begin
                inc_o    = inexact_o & ~sign_i;
                to_inf_o = ~sign_i;
            end
            default: begin
                inc_o    = inexact_o & sign_i;
                to_inf_o = sign_i;
            end
        endcase
    end
endmodule

// File: rtl/sp_packer.sv
module sp_packer
    import spk_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic                    in_sticky,
    input  logic [1:0]              rnd_mode,
    input  logic                    uf_trap_en,
    output logic                    out_valid,
    output logic [31:0]             out_word,
    output logic                    out_inexact,
    output logic                    out_underflow,
    output logic                    out_overflow
);
    localparam int BE_W = EXP_W + 2;
    localparam int SH_W = $clog2(MANT_W + 1);

    typedef struct packed {
        logic                   valid;
        cls_e                   cls;
        logic                   sign;
        rmode_e                 rm;
        logic                   trap;
        logic                   sub;
        logic signed [BE_W-1:0] bexp;
        logic [KEEP_W-1:0]      keep;
        logic [GR_W-1:0]        gr;
        logic                   st;
    } stg1_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
        logic        nx;
        logic        uf;
        logic        of;
    } stg2_t;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;

    logic signed [BE_W-1:0] be_d, shraw_d;
    logic [SH_W-1:0]        shamt_d;
    logic [MANT_W-1:0]      al_mant;
    logic                   al_st;
    logic                   r_inc, r_nx, r_inf;
    logic [KEEP_W:0]        sum_d;
    logic signed [BE_W-1:0] efin_d;

    spk_align #(.MW(MANT_W), .SH_W(SH_W)) u_align (
        .mant_i  (in_mant),
        .sticky_i(in_sticky),
        .shamt_i (shamt_d),
        .mant_o  (al_mant),
        .sticky_o(al_st)
    );

    spk_round u_round (
        .mode_i   (s1_q.rm),
        .sign_i   (s1_q.sign),
        .lsb_i    (s1_q.keep[0]),
        .gr_i     (s1_q.gr),
        .sticky_i (s1_q.st),
        .inc_o    (r_inc),
        .inexact_o(r_nx),
        .to_inf_o (r_inf)
    );

    always_comb begin
        // stage 1: bias and subnormal alignment
        be_d    = {{(BE_W-EXP_W){in_exp[EXP_W-1]}}, in_exp} + BE_W'(BIAS);
        shraw_d = BE_W'(1) - be_d;
        shamt_d = '0;
        if (cls_e'(in_class) == CLS_NUM && be_d <= 0) begin
            if (shraw_d > MANT_W) shamt_d = SH_W'(MANT_W);
            else                  shamt_d = shraw_d[SH_W-1:0];
        end
        s1_d.valid = in_valid;
        s1_d.cls   = cls_e'(in_class);
        s1_d.sign  = in_sign;
        s1_d.rm    = rmode_e'(rnd_mode);
        s1_d.trap  = uf_trap_en;
        s1_d.sub   = (be_d <= 0);
        s1_d.bexp  = be_d;
        s1_d.keep  = al_mant[MANT_W-1:GR_W];
        s1_d.gr    = al_mant[GR_W-1:0];
        s1_d.st    = al_st;

        // stage 2: round and pack
        sum_d  = {1'b0, s1_q.keep} + {{KEEP_W{1'b0}}, r_inc};
        efin_d = s1_q.bexp + signed'({{(BE_W-1){1'b0}}, sum_d[KEEP_W]});
        s2_d.valid = s1_q.valid;
        s2_d.nx    = 1'b0;
        s2_d.uf    = 1'b0;
        s2_d.of    = 1'b0;
        s2_d.word  = {s1_q.sign, 31'd0};
        unique case (s1_q.cls)
            CLS_ZERO: ;
            CLS_INF:  s2_d.word[30:0] = {EFLD_W'(EMAX), {FRAC_W{1'b0}}};
            CLS_NAN:  s2_d.word[30:0] = {EFLD_W'(EMAX), 1'b1, s1_q.keep[FRAC_W-2:0]};
            default: begin
                s2_d.nx = r_nx;
                if (s1_q.sub) begin
                    s2_d.word[30:0] = {{(EFLD_W-1){1'b0}}, sum_d[FRAC_W], sum_d[FRAC_W-1:0]};
                    s2_d.uf = ~sum_d[FRAC_W] & (r_nx | s1_q.trap);
                end else if (efin_d >= EMAX) begin
                    s2_d.of = 1'b1;
                    s2_d.nx = 1'b1;
                    if (r_inf) s2_d.word[30:0] = {EFLD_W'(EMAX), {FRAC_W{1'b0}}};
                    else       s2_d.word[30:0] = {EFLD_W'(EMAX - 1), {FRAC_W{1'b1}}};
                end else begin
                    s2_d.word[30:0] = {efin_d[EFLD_W-1:0], sum_d[FRAC_W-1:0]};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid     = s2_q.valid;
    assign out_word      = s2_q.word;
    assign out_inexact   = s2_q.nx;
    assign out_underflow = s2_q.uf;
    assign out_overflow  = s2_q.of;
endmodule

// File: rtl/spk_checks.sv
module spk_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_class,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        out_inexact,
    input logic        out_underflow,
    input logic        out_overflow
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R11
    AST_OVF_NX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> out_inexact); // R7
    AST_OVF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |->
        (out_word[30:0] == 31'h7F800000 || out_word[30:0] == 31'h7F7FFFFF)); // R7
    AST_UF_SUBNORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow) |-> (out_word[30:23] == 8'd0 && !out_overflow)); // R10
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[30:23] == 8'hFF && out_word[22:0] != 23'd0) |-> out_word[22]); // R3
    AST_SPECIAL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class != 2'd1) |-> ##2 (out_valid && !out_inexact && !out_underflow && !out_overflow)); // R1
endmodule

bind sp_packer spk_checks u_chk (.*);

// File: tb/sim_sp_packer.sv
module sim_sp_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = '0;
    logic        in_sign = 1'b0;
    logic signed [9:0] in_exp = '0;
    logic [25:0] in_mant = '0;
    logic        in_sticky = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic        uf_trap_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_inexact, out_underflow, out_overflow;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sp_packer u0 (.*);

    function automatic logic [25:0] mk(input logic [22:0] f, input logic [1:0] gr);
        return {1'b1, f, gr};
    endfunction

    task automatic check(input string tag, input logic [31:0] w, input logic nx,
                         input logic uf, input logic of);
        checks++;
        if (out_valid !== 1'b1 || out_word !== w || out_inexact !== nx ||
            out_underflow !== uf || out_overflow !== of) begin
            errors++;
            $display("FAIL %s: got v=%b w=%h nx=%b uf=%b of=%b, expected v=1 w=%h nx=%b uf=%b of=%b",
                     tag, out_valid, out_word, out_inexact, out_underflow, out_overflow,
                     w, nx, uf, of);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic s, input int e,
                         input logic [25:0] m, input logic st, input logic [1:0] rm,
                         input logic trap);
        in_valid   = 1'b1;
        in_class   = c;
        in_sign    = s;
        in_exp     = 10'(e);
        in_mant    = m;
        in_sticky  = st;
        rnd_mode   = rm;
        uf_trap_en = trap;
    endtask

    task automatic run1(input string tag, input logic [1:0] c, input logic s, input int e,
                        input logic [25:0] m, input logic st, input logic [1:0] rm,
                        input logic trap, input logic [31:0] w, input logic nx,
                        input logic uf, input logic of);
        @(negedge clk);
        drive(c, s, e, m, st, rm, trap);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(tag, w, nx, uf, of);
    endtask

    task automatic t_reset;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got out_valid=%b expected 0", out_valid);
        end
    endtask

    task automatic t_specials; // R1 R2 R3
        run1("R1 neg zero", 2'd0, 1'b1, 5, mk(23'h7, 2'b11), 1'b1, 2'd0, 1'b1, 32'h80000000, 0, 0, 0);
        run1("R2 pos inf", 2'd2, 1'b0, 0, mk(0, 0), 1'b0, 2'd1, 1'b0, 32'h7F800000, 0, 0, 0);
        run1("R3 nan quiet", 2'd3, 1'b1, 0, mk(23'h012345, 2'b11), 1'b1, 2'd0, 1'b0, 32'hFFC12345, 0, 0, 0);
    endtask

    task automatic t_normal; // R4
        run1("R4 exact 1.25", 2'd1, 1'b0, 0, mk(23'h200000, 0), 1'b0, 2'd0, 1'b0, 32'h3FA00000, 0, 0, 0);
        run1("R4 exact neg", 2'd1, 1'b1, -5, mk(23'h000001, 0), 1'b0, 2'd1, 1'b0, 32'hBD000001, 0, 0, 0);
    endtask

    task automatic t_round; // R5
        run1("R5 near tie odd", 2'd1, 1'b0, 0, mk(1, 2'b10), 1'b0, 2'd0, 1'b0, 32'h3F800002, 1, 0, 0);
        run1("R5 near tie even", 2'd1, 1'b0, 0, mk(2, 2'b10), 1'b0, 2'd0, 1'b0, 32'h3F800002, 1, 0, 0);
        run1("R5 near sticky", 2'd1, 1'b0, 0, mk(1, 2'b00), 1'b1, 2'd0, 1'b0, 32'h3F800001, 1, 0, 0);
        run1("R5 zero", 2'd1, 1'b0, 0, mk(1, 2'b11), 1'b0, 2'd1, 1'b0, 32'h3F800001, 1, 0, 0);
        run1("R5 up pos", 2'd1, 1'b0, 0, mk(1, 2'b01), 1'b0, 2'd2, 1'b0, 32'h3F800002, 1, 0, 0);
        run1("R5 down pos", 2'd1, 1'b0, 0, mk(1, 2'b01), 1'b0, 2'd3, 1'b0, 32'h3F800001, 1, 0, 0);
        run1("R5 down neg", 2'd1, 1'b1, 0, mk(1, 2'b01), 1'b0, 2'd3, 1'b0, 32'hBF800002, 1, 0, 0);
    endtask

    task automatic t_carry; // R6
        run1("R6 carry to 2.0", 2'd1, 1'b0, 0, mk(23'h7FFFFF, 2'b11), 1'b0, 2'd0, 1'b0, 32'h40000000, 1, 0, 0);
    endtask

    task automatic t_overflow; // R7
        run1("R7 near inf", 2'd1, 1'b0, 128, mk(0, 0), 1'b0, 2'd0, 1'b0, 32'h7F800000, 1, 0, 1);
        run1("R7 zero max", 2'd1, 1'b0, 128, mk(0, 0), 1'b0, 2'd1, 1'b0, 32'h7F7FFFFF, 1, 0, 1);
        run1("R7 up neg max", 2'd1, 1'b1, 200, mk(5, 0), 1'b0, 2'd2, 1'b0, 32'hFF7FFFFF, 1, 0, 1);
        run1("R7 down neg inf", 2'd1, 1'b1, 128, mk(0, 0), 1'b0, 2'd3, 1'b0, 32'hFF800000, 1, 0, 1);
        run1("R7 carry to inf", 2'd1, 1'b0, 127, mk(23'h7FFFFF, 2'b11), 1'b0, 2'd0, 1'b0, 32'h7F800000, 1, 0, 1);
    endtask

    task automatic t_subnormal; // R8 R10
        run1("R8 exact shift1", 2'd1, 1'b0, -127, mk(0, 0), 1'b0, 2'd0, 1'b0, 32'h00400000, 0, 0, 0);
        run1("R10 exact trap", 2'd1, 1'b0, -127, mk(0, 0), 1'b0, 2'd0, 1'b1, 32'h00400000, 0, 1, 0);
        run1("R8 exact shift4", 2'd1, 1'b1, -130, mk(0, 0), 1'b0, 2'd0, 1'b0, 32'h80080000, 0, 0, 0);
        run1("R10 inexact tie", 2'd1, 1'b0, -127, mk(1, 0), 1'b0, 2'd0, 1'b0, 32'h00400000, 1, 1, 0);
        run1("R8 tiny near", 2'd1, 1'b0, -200, mk(0, 0), 1'b0, 2'd0, 1'b0, 32'h00000000, 1, 1, 0);
        run1("R8 tiny up", 2'd1, 1'b0, -200, mk(0, 0), 1'b0, 2'd2, 1'b0, 32'h00000001, 1, 1, 0);
    endtask

    task automatic t_min_normal; // R9
        run1("R9 to min normal", 2'd1, 1'b0, -127, mk(23'h7FFFFF, 2'b11), 1'b0, 2'd0, 1'b0, 32'h00800000, 1, 0, 0);
        run1("R9 neg trap", 2'd1, 1'b1, -127, mk(23'h7FFFFF, 2'b11), 1'b0, 2'd0, 1'b1, 32'h80800000, 1, 0, 0);
    endtask

    task automatic t_stream; // R11
        @(negedge clk);
        drive(2'd2, 1'b1, 0, mk(0, 0), 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        drive(2'd1, 1'b0, 1, mk(0, 0), 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 stream first", 32'hFF800000, 0, 0, 0);
        @(negedge clk);
        check("R11 stream second", 32'h40000000, 0, 0, 0);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 idle after stream: got out_valid=%b expected 0", out_valid);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_specials();
        t_normal();
        t_round();
        t_carry();
        t_overflow();
        t_subnormal();
        t_min_normal();
        t_stream();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule